// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register-transfer datapath of a small processor built around one shared internal bus. A bank of general-purpose registers, the program counter, the instruction register, the memory address and memory data registers, an operand latch Y and a result latch Z all sit on that bus. An ALU takes one operand from a multiplexer that picks Y or a constant increment, and the other operand straight off the bus. The ALU result can only be stored in Z, and Z is a separate source on the bus.

There is no sequencer inside the block. Every out-enable, in-enable, ALU opcode and memory command comes in as a plain input, once per clock cycle. A controller outside the block puts these steps in order: one bus transfer per cycle, with separate steps for loading the operand, computing, and writing back. Memory is reached through a request that stays up until the memory returns an acknowledge. On a read, the acknowledge also delivers the data word into the memory data register.

Top module: `sbus_datapath`

## Requirements
- R1: The bus value equals the value of the single source whose out-enable is high. The sources are each general register, PC, Z, MDR and the IR offset field. When no out-enable is high the bus is all zeros.
- R2: A register whose in-enable is high loads the bus value at the rising clock edge. A register whose in-enable is low keeps its value.
- R3: ALU operand A is Y when sel_four is 0 and the constant 4 when sel_four is 1. Operand B is the bus. Z loads the ALU result only in a cycle with z_in_en high.
- R4: alu_op encodings: 000 add A+B, 001 subtract A−B, 010 AND, 011 OR, 100 XOR, 101 pass B, 110 pass A, 111 NOT B.
- R5: A register add takes three cycles and leaves the sum in the destination register. The three cycles are: source one to Y, then source two on the bus with add and z_in_en, then Z out to the destination.
- R6: flag_n is bit 31 of the result and flag_z is 1 when the result is zero. Both are stored when z_in_en is high and held otherwise.
- R7: ir_in_en loads IR from the bus and ir_value shows IR. ir_off_out_en drives the low 16 bits of IR, sign-extended to 32 bits, onto the bus.
- R8: A cycle with mem_rd high while no request is pending raises mem_req from the next cycle, with mem_we low and mem_addr equal to MAR. mem_req stays high until a cycle with mem_ack high. In that cycle mem_done is high, MDR captures mem_rdata and the request drops.
- R9: A cycle with mem_wr high while no request is pending raises mem_req with mem_we high. mem_wdata shows MDR.
- R10: mem_rd or mem_wr asserted while a request is pending is ignored. The pending request's direction and state are unchanged.
- R11: In a read acknowledge cycle that also has mdr_in_en high, MDR takes the bus value.
- R12: After reset all registers, flags and the request are zero. PC is 0.
- R13: Two fetch increments (PC out with sel_four, add and z_in_en, then Z out to PC) advance PC by 4 each time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpr_out_en | input | 8 | Out-enable per general register |
| gpr_in_en | input | 8 | In-enable per general register |
| pc_out_en | input | 1 | Drive PC on the bus |
| pc_in_en | input | 1 | Load PC from the bus |
| ir_in_en | input | 1 | Load IR from the bus |
| ir_off_out_en | input | 1 | Drive the extended IR offset on the bus |
| mar_in_en | input | 1 | Load MAR from the bus |
| mdr_out_en | input | 1 | Drive MDR on the bus |
| mdr_in_en | input | 1 | Load MDR from the bus |
| y_in_en | input | 1 | Load Y from the bus |
| z_out_en | input | 1 | Drive Z on the bus |
| z_in_en | input | 1 | Load Z and the flags from the ALU |
| sel_four | input | 1 | ALU A operand: 0 = Y, 1 = constant 4 |
| alu_op | input | 3 | ALU operation code |
| mem_rd | input | 1 | Start a memory read |
| mem_wr | input | 1 | Start a memory write |
| mem_ack | input | 1 | Memory completion |
| mem_rdata | input | 32 | Memory read data |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Pending request is a write |
| mem_addr | output | 32 | MAR contents |
| mem_wdata | output | 32 | MDR contents |
| mem_done | output | 1 | Request completes this cycle |
| bus_value | output | 32 | Current internal bus value |
| ir_value | output | 32 | IR contents |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |

## Verification
The assertions assume that the controller drives at most one out-enable per cycle and never raises mem_rd and mem_wr together. They also assume that mem_ack comes only while a request is pending. The stimulus is built from short step sequences that each set one source and any number of destinations. The acknowledge is raised only in the cycle after a request began or later. A reference model in the bench tracks every register and the request state, and its bus, memory and flag outputs are compared with the design's on every cycle.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
   typedef enum logic [2:0] {
      ALU_ADD   = 3'd0,
      ALU_SUB   = 3'd1,
      ALU_AND   = 3'd2,
      ALU_OR    = 3'd3,
      ALU_XOR   = 3'd4,
      ALU_PASSB = 3'd5,
      ALU_PASSA = 3'd6,
      ALU_NOTB  = 3'd7
   } alu_op_e;
endpackage

// File: rtl/sbus_gpr_bank.sv
module sbus_gpr_bank #(
   parameter int DATA_W = 32,
   parameter int NREG   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NREG-1:0]   load,
   input  logic [NREG-1:0]   drive,
   input  logic [DATA_W-1:0] bus,
   output logic [DATA_W-1:0] drv_val
);
   logic [DATA_W-1:0] q     [NREG];
   logic [DATA_W-1:0] gated [NREG];

   if (NREG < 2) begin : g_bad_nreg
      $error("sbus_gpr_bank: NREG must be at least 2");
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       q[i] <= '0;
         else if (load[i]) q[i] <= bus;
      end
      assign gated[i] = drive[i] ? q[i] : '0;

      // R2: an unselected register keeps its contents
      p_gpr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !load[i] |=> q[i] == $past(q[i]));
   end

   always_comb begin
      drv_val = '0;
      for (int i = 0; i < NREG; i++) drv_val = drv_val | gated[i];
   end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
   import sbus_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int INC_CONST = 4
) (
   input  logic [DATA_W-1:0] y_val,
   input  logic [DATA_W-1:0] bus,
   input  logic              sel_four,
   input  alu_op_e           op,
   output logic [DATA_W-1:0] res,
   output logic              res_neg,
   output logic              res_zero
);
   localparam logic [DATA_W-1:0] K_INC = DATA_W'(INC_CONST);

   logic [DATA_W-1:0] a_op;

   if (INC_CONST <= 0) begin : g_bad_inc
      $error("sbus_alu: INC_CONST must be positive");
   end

   assign a_op = sel_four ? K_INC : y_val;

   always_comb begin
      unique case (op)
         ALU_ADD:   res = a_op + bus;
         ALU_SUB:   res = a_op - bus;
         ALU_AND:   res = a_op & bus;
         ALU_OR:    res = a_op | bus;
         ALU_XOR:   res = a_op ^ bus;
         ALU_PASSB: res = bus;
         ALU_PASSA: res = a_op;
         default:   res = ~bus;
      endcase
   end

   assign res_neg  = res[DATA_W-1];
   assign res_zero = (res == '0);
endmodule

// File: rtl/sbus_mem_port.sv
module sbus_mem_port #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] bus,
   input  logic              mar_load,
   input  logic              mdr_load,
   input  logic              rd_cmd,
   input  logic              wr_cmd,
   input  logic              ack,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] mar_q,
   output logic [DATA_W-1:0] mdr_q,
   output logic              req,
   output logic              we,
   output logic              done
);
   logic rd_capture;

   assign done       = req & ack;
   assign rd_capture = done & ~we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mar_q <= '0;
      else if (mar_load) mar_q <= bus;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mdr_q <= '0;
      else if (mdr_load)   mdr_q <= bus;
      else if (rd_capture) mdr_q <= rdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req <= 1'b0;
         we  <= 1'b0;
      end else if (req) begin
         if (ack) req <= 1'b0;
      end else if (rd_cmd) begin
         req <= 1'b1;
         we  <= 1'b0;
      end else if (wr_cmd) begin
         req <= 1'b1;
         we  <= 1'b1;
      end
   end

   // R8: controller never asks for read and write together
   p_rw_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_cmd && wr_cmd));
   // R8: a pending request persists until acknowledged
   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req && !ack |=> req);
   // R8: the acknowledge cycle ends the request
   p_req_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !req);
   // R10: direction is stable while a request is pending
   p_dir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> we == $past(we));
   // R8: read data lands in MDR after an acknowledge without bus load
   p_rd_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_capture && !mdr_load |=> mdr_q == $past(rdata));
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
   import sbus_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int NREG          = 8,
   parameter int OFFSET_W      = 16,
   parameter bit OFFSET_SIGNED = 1'b1,
   parameter int INC_CONST     = 4,
   parameter logic [DATA_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NREG-1:0]   gpr_out_en,
   input  logic [NREG-1:0]   gpr_in_en,
   input  logic              pc_out_en,
   input  logic              pc_in_en,
   input  logic              ir_in_en,
   input  logic              ir_off_out_en,
   input  logic              mar_in_en,
   input  logic              mdr_out_en,
   input  logic              mdr_in_en,
   input  logic              y_in_en,
   input  logic              z_out_en,
   input  logic              z_in_en,
   input  logic              sel_four,
   input  logic [2:0]        alu_op,
   input  logic              mem_rd,
   input  logic              mem_wr,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_done,
   output logic [DATA_W-1:0] bus_value,
   output logic [DATA_W-1:0] ir_value,
   output logic              flag_n,
   output logic              flag_z
);
   localparam int EXT_W = DATA_W - OFFSET_W;

   if (DATA_W < 8) begin : g_bad_width
      $error("sbus_datapath: DATA_W must be at least 8");
   end
   if (OFFSET_W < 1 || OFFSET_W >= DATA_W) begin : g_bad_offset
      $error("sbus_datapath: OFFSET_W must lie in 1..DATA_W-1");
   end

   logic [DATA_W-1:0] bus;
   logic [DATA_W-1:0] gpr_drv;
   logic [DATA_W-1:0] pc_q, ir_q, y_q, z_q;
   logic [DATA_W-1:0] mar_q, mdr_q;
   logic [DATA_W-1:0] ir_off;
   logic [DATA_W-1:0] alu_res;
   logic              alu_neg, alu_zero;
   logic              n_q, zf_q;

   if (OFFSET_SIGNED) begin : g_off_sext
      assign ir_off = {{EXT_W{ir_q[OFFSET_W-1]}}, ir_q[OFFSET_W-1:0]};
   end else begin : g_off_zext
      assign ir_off = {{EXT_W{1'b0}}, ir_q[OFFSET_W-1:0]};
   end

   sbus_gpr_bank #(.DATA_W(DATA_W), .NREG(NREG)) u_gpr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (gpr_in_en),
      .drive   (gpr_out_en),
      .bus     (bus),
      .drv_val (gpr_drv)
   );

   always_comb begin
      bus = gpr_drv;
      if (pc_out_en)     bus = bus | pc_q;
      if (z_out_en)      bus = bus | z_q;
      if (mdr_out_en)    bus = bus | mdr_q;
      if (ir_off_out_en) bus = bus | ir_off;
   end

   sbus_alu #(.DATA_W(DATA_W), .INC_CONST(INC_CONST)) u_alu (
      .y_val    (y_q),
      .bus      (bus),
      .sel_four (sel_four),
      .op       (alu_op_e'(alu_op)),
      .res      (alu_res),
      .res_neg  (alu_neg),
      .res_zero (alu_zero)
   );

   sbus_mem_port #(.DATA_W(DATA_W)) u_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus      (bus),
      .mar_load (mar_in_en),
      .mdr_load (mdr_in_en),
      .rd_cmd   (mem_rd),
      .wr_cmd   (mem_wr),
      .ack      (mem_ack),
      .rdata    (mem_rdata),
      .mar_q    (mar_q),
      .mdr_q    (mdr_q),
      .req      (mem_req),
      .we       (mem_we),
      .done     (mem_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pc_q <= RESET_PC;
      else if (pc_in_en) pc_q <= bus;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ir_q <= '0;
      else if (ir_in_en) ir_q <= bus;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       y_q <= '0;
      else if (y_in_en) y_q <= bus;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         z_q  <= '0;
         n_q  <= 1'b0;
         zf_q <= 1'b0;
      end else if (z_in_en) begin
         z_q  <= alu_res;
         n_q  <= alu_neg;
         zf_q <= alu_zero;
      end
   end

   assign mem_addr  = mar_q;
   assign mem_wdata = mdr_q;
   assign bus_value = bus;
   assign ir_value  = ir_q;
   assign flag_n    = n_q;
   assign flag_z    = zf_q;

   // R1: at most one source drives the bus in any cycle
   p_one_driver_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({gpr_out_en, pc_out_en, z_out_en, mdr_out_en, ir_off_out_en}) <= 1);
   // R3: Z takes the ALU result of the capture cycle
   p_z_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      z_in_en |=> z_q == $past(alu_res));
   // R3: without z_in_en the result latch holds
   p_z_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !z_in_en |=> $stable(z_q));
   // R6: stored flags agree with the stored result
   p_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      z_in_en |=> (flag_n == z_q[DATA_W-1]) && (flag_z == (z_q == '0)));
   // R1: an idle bus reads as zero
   p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({gpr_out_en, pc_out_en, z_out_en, mdr_out_en, ir_off_out_en}) == 0
      |-> bus_value == '0);
endmodule

// File: tb/sbus_datapath_test.sv
module sbus_datapath_test;
   timeunit 1ns;
   timeprecision 100ps;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0]  gpr_out_en, gpr_in_en;
   logic        pc_out_en, pc_in_en, ir_in_en, ir_off_out_en, mar_in_en;
   logic        mdr_out_en, mdr_in_en, y_in_en, z_out_en, z_in_en, sel_four;
   logic [2:0]  alu_op;
   logic        mem_rd, mem_wr, mem_ack;
   logic [31:0] mem_rdata;
   logic        mem_req, mem_we, mem_done, flag_n, flag_z;
   logic [31:0] mem_addr, mem_wdata, bus_value, ir_value;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [31:0] m_gpr [8];
   logic [31:0] m_pc, m_ir, m_mar, m_mdr, m_y, m_z;
   logic        m_n, m_zf, m_req, m_we;

   always #2 clk = ~clk;

   sbus_datapath uut (
      .clk(clk), .rst_n(rst_n), .gpr_out_en(gpr_out_en), .gpr_in_en(gpr_in_en),
      .pc_out_en(pc_out_en), .pc_in_en(pc_in_en), .ir_in_en(ir_in_en),
      .ir_off_out_en(ir_off_out_en), .mar_in_en(mar_in_en), .mdr_out_en(mdr_out_en),
      .mdr_in_en(mdr_in_en), .y_in_en(y_in_en), .z_out_en(z_out_en), .z_in_en(z_in_en),
      .sel_four(sel_four), .alu_op(alu_op), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_done(mem_done),
      .bus_value(bus_value), .ir_value(ir_value), .flag_n(flag_n), .flag_z(flag_z)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      gpr_out_en = '0; gpr_in_en = '0;
      pc_out_en = 0; pc_in_en = 0; ir_in_en = 0; ir_off_out_en = 0; mar_in_en = 0;
      mdr_out_en = 0; mdr_in_en = 0; y_in_en = 0; z_out_en = 0; z_in_en = 0;
      sel_four = 0; alu_op = 3'd0; mem_rd = 0; mem_wr = 0; mem_ack = 0; mem_rdata = '0;
   endtask

   function automatic logic [31:0] m_bus();
      logic [31:0] b = '0;
      for (int i = 0; i < 8; i++) if (gpr_out_en[i]) b |= m_gpr[i];
      if (pc_out_en)     b |= m_pc;
      if (z_out_en)      b |= m_z;
      if (mdr_out_en)    b |= m_mdr;
      if (ir_off_out_en) b |= {{16{m_ir[15]}}, m_ir[15:0]};
      return b;
   endfunction

   function automatic logic [31:0] m_alu(logic [31:0] a, logic [31:0] b, logic [2:0] op);
      case (op)
         3'd0: return a + b;
         3'd1: return a - b;
         3'd2: return a & b;
         3'd3: return a | b;
         3'd4: return a ^ b;
         3'd5: return b;
         3'd6: return a;
         default: return ~b;
      endcase
   endfunction

   task automatic m_reset();
      for (int i = 0; i < 8; i++) m_gpr[i] = '0;
      m_pc = '0; m_ir = '0; m_mar = '0; m_mdr = '0; m_y = '0; m_z = '0;
      m_n = 0; m_zf = 0; m_req = 0; m_we = 0;
   endtask

   // one cycle: compare against the model, then advance the model at the edge
   task automatic tick();
      logic [31:0] b, r;
      int drivers;
      #0.5;
      drivers = $countones({gpr_out_en, pc_out_en, z_out_en, mdr_out_en, ir_off_out_en});
      chk("R1 single driver", (drivers <= 1), 1);
      chk("R1 bus", bus_value, m_bus());
      chk("R8 req", mem_req, m_req);
      chk("R9 we", mem_we, m_we);
      chk("R8 addr", mem_addr, m_mar);
      chk("R9 wdata", mem_wdata, m_mdr);
      chk("R8 done", mem_done, m_req & mem_ack);
      chk("R7 ir", ir_value, m_ir);
      chk("R6 n", flag_n, m_n);
      chk("R6 z", flag_z, m_zf);
      @(posedge clk);
      b = m_bus();
      r = m_alu(sel_four ? 32'd4 : m_y, b, alu_op);
      for (int i = 0; i < 8; i++) if (gpr_in_en[i]) m_gpr[i] = b;
      if (pc_in_en)  m_pc  = b;
      if (ir_in_en)  m_ir  = b;
      if (mar_in_en) m_mar = b;
      if (y_in_en)   m_y   = b;
      if (z_in_en) begin m_z = r; m_n = r[31]; m_zf = (r == 0); end
      if (mdr_in_en) m_mdr = b;
      else if (m_req && !m_we && mem_ack) m_mdr = mem_rdata;
      if (m_req) begin
         if (mem_ack) m_req = 0;
      end else if (mem_rd) begin m_req = 1; m_we = 0; end
      else if (mem_wr) begin m_req = 1; m_we = 1; end
      @(negedge clk);
      idle();
   endtask

   task automatic see(string tag, logic [31:0] exp);
      #0.2;
      chk(tag, bus_value, exp);
   endtask

   task automatic load_gpr(int idx, logic [31:0] v);
      pc_out_en = 1; mar_in_en = 1; mem_rd = 1; tick();
      mem_ack = 1; mem_rdata = v;
      #0.2 chk("R8 done on ack", mem_done, 1);
      tick();
      mdr_out_en = 1; gpr_in_en[idx] = 1; see("R8 mdr read data", v); tick();
   endtask

   task automatic read_gpr(int idx, logic [31:0] exp, string tag);
      gpr_out_en[idx] = 1; see(tag, exp); tick();
   endtask

   task automatic alu_run(int s1, int s2, logic [2:0] op, int dst);
      gpr_out_en[s1] = 1; y_in_en = 1; tick();
      gpr_out_en[s2] = 1; alu_op = op; z_in_en = 1; tick();
      z_out_en = 1; gpr_in_en[dst] = 1; tick();
   endtask

   initial begin
      #(4.0 * 200000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      idle();
      m_reset();
      repeat (3) @(negedge clk);
      chk("R12 bus after reset", bus_value, 0);
      chk("R12 req after reset", mem_req, 0);
      chk("R12 ir after reset", ir_value, 0);
      chk("R12 flags after reset", {flag_n, flag_z}, 0);
      rst_n = 1;
      pc_out_en = 1; see("R12 pc reset", 32'h0); tick();
      z_out_en = 1; see("R12 z reset", 32'h0); tick();

      load_gpr(1, 32'h1234_5678);
      load_gpr(2, 32'h0F0F_0F0F);
      load_gpr(5, 32'h8000_0000);
      load_gpr(6, 32'h1234_5678);

      alu_run(1, 2, 3'd0, 3);
      read_gpr(3, 32'h2143_6587, "R5 register add");

      alu_run(1, 2, 3'd1, 4); read_gpr(4, 32'h0325_4769, "R4 sub");
      alu_run(1, 2, 3'd2, 4); read_gpr(4, 32'h0204_0608, "R4 and");
      alu_run(1, 2, 3'd3, 4); read_gpr(4, 32'h1F3F_5F7F, "R4 or");
      alu_run(1, 2, 3'd4, 4); read_gpr(4, 32'h1D3B_5977, "R4 xor");
      alu_run(1, 2, 3'd5, 4); read_gpr(4, 32'h0F0F_0F0F, "R4 pass b");
      alu_run(1, 2, 3'd6, 4); read_gpr(4, 32'h1234_5678, "R4 pass a");
      alu_run(1, 2, 3'd7, 4); read_gpr(4, 32'hF0F0_F0F0, "R4 not b");
      chk("R6 negative flag", {flag_n, flag_z}, 2'b10);
      alu_run(1, 6, 3'd1, 4);
      chk("R6 zero flag", {flag_n, flag_z}, 2'b01);

      gpr_out_en[1] = 1; sel_four = 1; alu_op = 3'd0; z_in_en = 1; tick();
      z_out_en = 1; see("R3 constant four", 32'h1234_567C); tick();
      gpr_out_en[2] = 1; alu_op = 3'd0; tick();
      z_out_en = 1; see("R3 no capture without z_in", 32'h1234_567C); tick();
      chk("R6 flags held", {flag_n, flag_z}, 2'b00);

      for (int k = 0; k < 2; k++) begin
         pc_out_en = 1; mar_in_en = 1; sel_four = 1; alu_op = 3'd0; z_in_en = 1; tick();
         z_out_en = 1; pc_in_en = 1; y_in_en = 1; tick();
      end
      pc_out_en = 1; see("R13 pc after two fetches", 32'd8); tick();

      load_gpr(7, 32'h1234_8001);
      gpr_out_en[7] = 1; ir_in_en = 1; tick();
      #0.2 chk("R7 ir load", ir_value, 32'h1234_8001);
      ir_off_out_en = 1; see("R7 negative offset", 32'hFFFF_8001); tick();
      load_gpr(7, 32'hABCD_1234);
      gpr_out_en[7] = 1; ir_in_en = 1; tick();
      ir_off_out_en = 1; see("R7 positive offset", 32'h0000_1234); tick();

      gpr_out_en[5] = 1; mar_in_en = 1; tick();
      gpr_out_en[6] = 1; mdr_in_en = 1; mem_wr = 1; tick();
      #0.2;
      chk("R9 write req", {mem_req, mem_we}, 2'b11);
      chk("R9 write addr", mem_addr, 32'h8000_0000);
      chk("R9 write data", mem_wdata, 32'h1234_5678);
      mem_rd = 1; tick();
      #0.2 chk("R10 read ignored while pending", {mem_req, mem_we}, 2'b11);
      mem_ack = 1; tick();
      #0.2 chk("R8 req cleared", mem_req, 0);
      mdr_out_en = 1; see("R10 mdr unchanged by write ack", 32'h1234_5678); tick();

      pc_out_en = 1; mar_in_en = 1; mem_rd = 1; tick();
      mem_ack = 1; mem_rdata = 32'hDEAD_BEEF; gpr_out_en[2] = 1; mdr_in_en = 1; tick();
      mdr_out_en = 1; see("R11 bus load wins", 32'h0F0F_0F0F); tick();

      read_gpr(1, 32'h1234_5678, "R2 register held");
      tick();

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule